// File: doc/BRIEF.md
# Periodic Self-Calibration Scheduler

This block decides when a current-sense self-calibration runs on a pair of channels, and runs it in order. Software controls it through a three-bit control field. A command bit starts one calibration and clears itself when the calibration is over. A self-timed bit repeats the calibration once every period. A mode bit chooses between acquisition and tracking. In acquisition, passes run back to back until the residual error is small enough. In tracking, a single pass runs each time and a sample-and-hold signal is raised for that pass.

The analog engine sits outside the block. The block talks to it through a level request, a channel select and a one-cycle completion strobe. An error-small flag comes with the strobe. A pass calibrates channel 1 first and then channel 2. The period is a parameter counted in clock cycles. Its default is 15 ms at 200 MHz, and a test can set a short value.

Top module: `selfcal_sched`

## Requirements
- R1: After reset the control readback is 3'b000, and cal_req, sh_hold and routine_done are all 0.
- R2: A write with bit 1 (command) set while idle raises cal_req with cal_chan=0 on the next clock. The readback of bit 1 then shows 1.
- R3: A pass serves channel 1 (cal_chan=0) until cal_done, then channel 2 (cal_chan=1) until cal_done. When the final pass completes, routine_done pulses for one cycle, cal_req falls and the command bit reads 0, all in that same cycle.
- R4: In acquisition (effective mode 0), if cal_err_ok is low at either channel's cal_done, a new pass starts on channel 1 in the very next cycle. routine_done stays low and the command bit stays 1.
- R5: In tracking (bit 2 = 1), one pass runs whatever cal_err_ok reports, and sh_hold is 1 for the whole pass.
- R6: While bit 0 (self-timed) is 1 and the block is idle, cal_req rises exactly PERIOD_CYC cycles after the write that set bit 0.
- R7: After any routine ends with bit 0 set, the next self-timed start comes exactly PERIOD_CYC cycles after the routine_done cycle. A commanded routine restarts the timer in the same way.
- R8: Until one acquisition routine has converged after reset, bit 2 is treated as 0: passes repeat on a poor error and sh_hold stays 0.
- R9: A command write that arrives during a routine is absorbed. The running pass keeps its channel, and only one routine_done follows.
- R10: With bit 0 clear, no calibration starts by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Write data: [2] mode, [1] command, [0] self-timed |
| ctl_rdata | output | 3 | Control readback, same bit layout |
| cal_req | output | 1 | Calibration request to the engine (level) |
| cal_chan | output | 1 | Channel under calibration: 0 = channel 1, 1 = channel 2 |
| cal_done | input | 1 | One-cycle completion strobe from the engine |
| cal_err_ok | input | 1 | Residual error at or below threshold, valid with cal_done |
| sh_hold | output | 1 | Sample-and-hold enable during a tracking pass |
| routine_done | output | 1 | One-cycle pulse at the end of the final pass |

## Verification
A wrong pass state shows at the ports in the cycle after the engine strobe. The symptom is cal_chan on the wrong channel, or cal_req falling when a repeat was due. A corrupted timer shows up as a start one cycle early or late against the exact period count, so every period check is done at cycle granularity. If the first-routine mode flag is lost, sh_hold rises on the first routine after reset. If the command bit fails to clear, the readback shows it in the routine_done cycle.

// File: rtl/selfcal_sched.sv
module selfcal_sched #(
  parameter int unsigned PERIOD_CYC = 3_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [2:0] ctl_wdata,
  output logic [2:0] ctl_rdata,
  output logic       cal_req,
  output logic       cal_chan,
  input  logic       cal_done,
  input  logic       cal_err_ok,
  output logic       sh_hold,
  output logic       routine_done
);
  localparam int CW = $clog2(PERIOD_CYC + 1);
  localparam logic [CW-1:0] TLAST = CW'(PERIOD_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_CH1, S_CH2} st_t;

  st_t           st;
  logic          mode_q, cmd_q, auto_q, seeded_q, trk_q, ok1_q;
  logic [CW-1:0] tmr_q;

  wire busy     = (st != S_IDLE);
  wire mode_nx  = ctl_wr ? ctl_wdata[2] : mode_q;
  wire tmr_hit  = auto_q && !busy && (tmr_q == TLAST);
  wire cmd_go   = ctl_wr && ctl_wdata[1] && !busy;
  wire start    = cmd_go || tmr_hit;
  wire pass_end = (st == S_CH2) && cal_done;
  wire again    = pass_end && !trk_q && !(ok1_q && cal_err_ok);
  wire finish   = pass_end && !again;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      mode_q       <= 1'b0;
      cmd_q        <= 1'b0;
      auto_q       <= 1'b0;
      seeded_q     <= 1'b0;
      trk_q        <= 1'b0;
      ok1_q        <= 1'b0;
      tmr_q        <= '0;
      routine_done <= 1'b0;
    end else begin
      routine_done <= finish;
      if (ctl_wr) begin
        mode_q <= ctl_wdata[2];
        auto_q <= ctl_wdata[0];
      end
      if (finish)      cmd_q <= 1'b0;
      else if (cmd_go) cmd_q <= 1'b1;
      if (!auto_q || busy || tmr_hit) tmr_q <= '0;
      else                            tmr_q <= tmr_q + 1'b1;
      if (finish && !trk_q) seeded_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_CH1;
          trk_q <= mode_nx && seeded_q;
        end
        S_CH1: if (cal_done) begin
          ok1_q <= cal_err_ok;
          st    <= S_CH2;
        end
        S_CH2: if (cal_done) st <= again ? S_CH1 : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctl_rdata = {mode_q, cmd_q, auto_q};
  assign cal_req   = busy;
  assign cal_chan  = (st == S_CH2);
  assign sh_hold   = busy && trk_q;

  a_r3_first_chan: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_req) |-> !cal_chan);
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    routine_done |-> (!cal_req && !ctl_rdata[1]));
  a_r5_hold_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    sh_hold |-> cal_req);
  a_r8_no_early_track: assert property (@(posedge clk) disable iff (!rst_n)
    !seeded_q |-> !sh_hold);
  a_r9_absorb: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && ctl_wr && !cal_done) |=> (cal_req && $stable(cal_chan)));
  a_r6_tmr_range: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= TLAST);
endmodule

// File: tb/selfcal_sched_bench.sv
`timescale 1ns/1ps
module selfcal_sched_bench;
  localparam int P = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = 3'b000;
  logic [2:0] ctl_rdata;
  logic       cal_req, cal_chan, sh_hold, routine_done;
  logic       cal_done = 1'b0;
  logic       cal_err_ok = 1'b0;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  selfcal_sched #(.PERIOD_CYC(P)) u_selfcal_sched (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cal_req(cal_req), .cal_chan(cal_chan),
    .cal_done(cal_done), .cal_err_ok(cal_err_ok), .sh_hold(sh_hold),
    .routine_done(routine_done));

  // {mode, ok ch1, ok ch2, expect repeat, expect hold}
  localparam logic [4:0] VEC [5] = '{
    5'b10001, 5'b01010, 5'b01100, 5'b11001, 5'b00110 };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic strobe(input logic ok);
    cal_done = 1'b1; cal_err_ok = ok;
    @(posedge clk); @(negedge clk);
    cal_done = 1'b0; cal_err_ok = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_bench;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      finish_bench();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", int'(ctl_rdata), 0);
    chk("R1 req", int'(cal_req), 0);
    chk("R1 hold", int'(sh_hold), 0);
    chk("R1 done", int'(routine_done), 0);

    // R8: tracking requested before any converged acquisition
    wr(3'b110);
    chk("R8 req", int'(cal_req), 1);
    chk("R8 hold", int'(sh_hold), 0);
    strobe(1'b0);
    strobe(1'b1);
    chk("R8 repeat", int'(cal_req && !cal_chan), 1);
    chk("R8 no done", int'(routine_done), 0);
    strobe(1'b1);
    strobe(1'b1);
    chk("R8 done", int'(routine_done), 1);
    idle(1);

    foreach (VEC[k]) begin
      logic [4:0] v;
      v = VEC[k];
      wr({v[4], 1'b1, 1'b0});
      chk("R2 req", int'(cal_req), 1);
      chk("R2 cmd bit", int'(ctl_rdata[1]), 1);
      chk("R3 ch1", int'(cal_chan), 0);
      chk("R5 hold", int'(sh_hold), int'(v[0]));
      strobe(v[3]);
      chk("R3 ch2", int'(cal_chan), 1);
      chk("R5 hold ch2", int'(sh_hold), int'(v[0]));
      strobe(v[2]);
      if (v[1]) begin
        chk("R4 repeat req", int'(cal_req), 1);
        chk("R4 repeat ch1", int'(cal_chan), 0);
        chk("R4 no done", int'(routine_done), 0);
        chk("R4 cmd held", int'(ctl_rdata[1]), 1);
        strobe(1'b1);
        strobe(1'b1);
      end
      chk("R3 done pulse", int'(routine_done), 1);
      chk("R3 cmd clear", int'(ctl_rdata[1]), 0);
      chk("R3 req low", int'(cal_req), 0);
      idle(1);
      chk("R3 pulse width", int'(routine_done), 0);
    end

    // R9: command during a routine is absorbed
    wr(3'b010);
    wr(3'b010);
    chk("R9 still ch1", int'(cal_req && !cal_chan), 1);
    strobe(1'b1);
    wr(3'b010);
    chk("R9 still ch2", int'(cal_req && cal_chan), 1);
    strobe(1'b1);
    chk("R9 done", int'(routine_done), 1);
    idle(1);
    chk("R9 no restart", int'(cal_req), 0);
    chk("R9 single done", int'(routine_done), 0);

    // R6: first self-timed start
    wr(3'b001);
    idle(P - 1);
    chk("R6 early", int'(cal_req), 0);
    idle(1);
    chk("R6 start", int'(cal_req), 1);
    strobe(1'b1);
    strobe(1'b1);
    chk("R7 auto done", int'(routine_done), 1);
    idle(P - 1);
    chk("R7 early", int'(cal_req), 0);
    idle(1);
    chk("R7 periodic", int'(cal_req), 1);
    strobe(1'b1);
    strobe(1'b1);

    // R7: commanded run restarts the period
    idle(5);
    wr(3'b011);
    strobe(1'b1);
    strobe(1'b1);
    chk("R7 cmd done", int'(routine_done), 1);
    idle(P - 1);
    chk("R7 restart early", int'(cal_req), 0);
    idle(1);
    chk("R7 restart", int'(cal_req), 1);
    strobe(1'b1);
    strobe(1'b1);

    // R10: self-timed off
    wr(3'b000);
    idle(3 * P);
    chk("R10 no start", int'(cal_req), 0);
    chk("R10 rdata", int'(ctl_rdata), 0);

    finish_bench();
  end
endmodule